// File: doc/BRIEF.md
# Processor Operating Mode Decoder

This block condenses a processor's scattered control state into one registered mode word for the instruction decode logic. The inputs are the long-mode-active bit, the protection-enable and paging bits, the virtual-8086 flag, three attributes of the code segment (a long flag, a default-size flag and the privilege level) and the default-size flag of the stack segment. From these it derives the major mode, the submode, the privilege level, the two paging and protection flags, and a default and alternate size code for each of operand, address and stack width. The stack has only one size.

The word does not follow the inputs continuously. It loads on the clock edge that ends a cycle in which `ctl_wr` is high, meaning a control register was written and the pins now show the new value. It also loads on the edge that ends a cycle in which `mode_wr` is high, meaning software wrote the mode register itself. In that case the written data is thrown away and the word is recomputed from the current pins. Between strobes the decode logic sees a stable word, even while several control inputs move over more than one cycle. The control pins are plain level signals and carry no handshake.

Size codes are the base-2 log of the width in bytes: 1 is 16-bit, 2 is 32-bit and 3 is 64-bit. The word is 18 bits wide. The packing of each field is given in the requirement that defines it.

Top module: `opmode_decoder`

## Requirements
- R1: While `rst_n` is low, `mode_word` is all zeros, even when a strobe is high.
- R2: `mode_word` changes only on a clock edge that ends a cycle with `ctl_wr` or `mode_wr` high. Changes on the control pins without a strobe leave it unchanged.
- R3: The value on `mode_wr_data` has no effect. A `mode_wr` load gives the same word for any data value.
- R4: With `lm_active` high, the major mode (bit 3) is 1. The submode (bits 2:0) is 4 (64-bit) when `cs_long` is high and 3 (compatibility) when it is low.
- R5: With `lm_active` low, the major mode (bit 3) is 0. The submode (bits 2:0) is 0 (real) when `ctl_pe` is low, 2 (virtual-8086) when `ctl_pe` and `fl_vm` are both high, and 1 (protected) when `ctl_pe` is high and `fl_vm` is low.
- R6: Bits 5:4 hold `cs_cpl`, bit 6 holds `ctl_pg` and bit 7 holds `ctl_pe`.
- R7: Take the submode to be 64-bit or `cs_big` to be high. Then the default operand code (bits 9:8) is 2 and the alternate (bits 11:10) is 1. Otherwise the default is 1 and the alternate is 2.
- R8: In the 64-bit submode the default address code (bits 13:12) is 3 and the alternate (bits 15:14) is 2. Otherwise, with `cs_big` high they are 2 and 1, and with `cs_big` low they are 1 and 2.
- R9: The stack code (bits 17:16) is 3 in the 64-bit submode. Otherwise it is 2 with `ss_big` high and 1 with `ss_big` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lm_active | input | 1 | Long mode is active |
| ctl_pe | input | 1 | Protection enable control bit |
| ctl_pg | input | 1 | Paging enable control bit |
| fl_vm | input | 1 | Virtual-8086 flag |
| cs_long | input | 1 | Code segment long flag |
| cs_big | input | 1 | Code segment default-size flag |
| cs_cpl | input | 2 | Code segment privilege level |
| ss_big | input | 1 | Stack segment default-size flag |
| ctl_wr | input | 1 | A control register was written this cycle |
| mode_wr | input | 1 | The mode register is written this cycle |
| mode_wr_data | input | 18 | Data of a mode register write (discarded) |
| mode_word | output | 18 | Registered packed mode word |

## Verification
The bench walks all 512 input combinations. This covers the case where `cs_long` is set in legacy mode, which must not produce 64-bit sizes. A design that keys the 64-bit submode on `cs_long` alone would report wide address and stack codes there. It also covers `cs_big` and `ss_big` in the 64-bit submode, where a decoder with the wrong priority would give 32-bit address or stack codes. The virtual-8086 flag is tested with protection off, where a decoder that skipped the protection check would leave real mode. Pin changes without a strobe test that the word holds. Two mode register writes with different data test that the data is discarded, and a design that stored that data would show it in the word.

// File: rtl/opm_pkg.sv
`timescale 1ns/1ps
package opm_pkg;
  localparam int CPL_W = 2;
  localparam int SZ_W  = 2;
  localparam int SUB_W = 3;

  typedef enum logic [SUB_W-1:0] {
    SUB_REAL   = 3'd0,
    SUB_PROT   = 3'd1,
    SUB_V86    = 3'd2,
    SUB_COMPAT = 3'd3,
    SUB_B64    = 3'd4
  } submode_e;

  localparam logic MAJ_LEGACY = 1'b0;
  localparam logic MAJ_LONG   = 1'b1;

  localparam logic [SZ_W-1:0] SZ16 = 2'd1;
  localparam logic [SZ_W-1:0] SZ32 = 2'd2;
  localparam logic [SZ_W-1:0] SZ64 = 2'd3;

  typedef struct packed {
    logic [SZ_W-1:0]  stk;
    logic [SZ_W-1:0]  ad_alt;
    logic [SZ_W-1:0]  ad_def;
    logic [SZ_W-1:0]  op_alt;
    logic [SZ_W-1:0]  op_def;
    logic             prot;
    logic             paging;
    logic [CPL_W-1:0] cpl;
    logic             major;
    submode_e         sub;
  } mode_word_t;

  localparam int WORD_W = $bits(mode_word_t);
endpackage

// File: rtl/opm_submode_sel.sv
`timescale 1ns/1ps
module opm_submode_sel
  import opm_pkg::*;
(
  input  logic     lm_active,
  input  logic     ctl_pe,
  input  logic     fl_vm,
  input  logic     cs_long,
  output logic     major,
  output submode_e sub,
  output logic     is64
);
  always_comb begin
    if (lm_active) begin
      major = MAJ_LONG;
      sub   = cs_long ? SUB_B64 : SUB_COMPAT;
    end else begin
      major = MAJ_LEGACY;
      if (!ctl_pe)     sub = SUB_REAL;
      else if (fl_vm)  sub = SUB_V86;
      else             sub = SUB_PROT;
    end
  end

  assign is64 = (sub == SUB_B64);
endmodule

// File: rtl/opm_size_sel.sv
`timescale 1ns/1ps
module opm_size_sel
  import opm_pkg::*;
(
  input  logic            is64,
  input  logic            cs_big,
  input  logic            ss_big,
  output logic [SZ_W-1:0] op_def,
  output logic [SZ_W-1:0] op_alt,
  output logic [SZ_W-1:0] ad_def,
  output logic [SZ_W-1:0] ad_alt,
  output logic [SZ_W-1:0] stk
);
  // Operand width never reaches 64 bits by default: 64-bit submode keeps 32.
  always_comb begin
    if (is64 || cs_big) begin
      op_def = SZ32;
      op_alt = SZ16;
    end else begin
      op_def = SZ16;
      op_alt = SZ32;
    end
  end

  // Address width: the 64-bit submode takes priority over the segment flag.
  always_comb begin
    if (is64) begin
      ad_def = SZ64;
      ad_alt = SZ32;
    end else if (cs_big) begin
      ad_def = SZ32;
      ad_alt = SZ16;
    end else begin
      ad_def = SZ16;
      ad_alt = SZ32;
    end
  end

  always_comb begin
    if (is64)        stk = SZ64;
    else if (ss_big) stk = SZ32;
    else             stk = SZ16;
  end
endmodule

// File: rtl/opm_word_reg.sv
`timescale 1ns/1ps
module opm_word_reg
  import opm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  mode_word_t d,
  output mode_word_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/opmode_decoder.sv
`timescale 1ns/1ps
module opmode_decoder
  import opm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lm_active,
  input  logic              ctl_pe,
  input  logic              ctl_pg,
  input  logic              fl_vm,
  input  logic              cs_long,
  input  logic              cs_big,
  input  logic [CPL_W-1:0]  cs_cpl,
  input  logic              ss_big,
  input  logic              ctl_wr,
  input  logic              mode_wr,
  input  logic [WORD_W-1:0] mode_wr_data,
  output logic [WORD_W-1:0] mode_word
);
  logic       major;
  submode_e   sub;
  logic       is64;
  mode_word_t next_w;
  mode_word_t cur_w;

  // Writes to the mode register only trigger a recompute; the data is dropped.
  logic unused_wr_data;
  assign unused_wr_data = ^mode_wr_data;

  opm_submode_sel u_mode (
    .lm_active (lm_active),
    .ctl_pe    (ctl_pe),
    .fl_vm     (fl_vm),
    .cs_long   (cs_long),
    .major     (major),
    .sub       (sub),
    .is64      (is64)
  );

  opm_size_sel u_size (
    .is64   (is64),
    .cs_big (cs_big),
    .ss_big (ss_big),
    .op_def (next_w.op_def),
    .op_alt (next_w.op_alt),
    .ad_def (next_w.ad_def),
    .ad_alt (next_w.ad_alt),
    .stk    (next_w.stk)
  );

  assign next_w.prot   = ctl_pe;
  assign next_w.paging = ctl_pg;
  assign next_w.cpl    = cs_cpl;
  assign next_w.major  = major;
  assign next_w.sub    = sub;

  opm_word_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ctl_wr | mode_wr),
    .d     (next_w),
    .q     (cur_w)
  );

  assign mode_word = cur_w;
endmodule

// File: rtl/opmode_decoder_chk.sv
`timescale 1ns/1ps
module opmode_decoder_chk
  import opm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              lm_active,
  input logic              ctl_pe,
  input logic              ctl_pg,
  input logic              fl_vm,
  input logic              cs_long,
  input logic              cs_big,
  input logic [CPL_W-1:0]  cs_cpl,
  input logic              ss_big,
  input logic              ctl_wr,
  input logic              mode_wr,
  input logic [WORD_W-1:0] mode_word
);
  mode_word_t w;
  logic       strobe;
  assign w      = mode_word;
  assign strobe = ctl_wr | mode_wr;

  always_comb begin
    if (!rst_n) p_reset_zero_r1: assert (mode_word == '0);
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(mode_word));

  p_long_sub_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && lm_active |=>
      w.major == 1'b1 &&
      w.sub == ($past(cs_long) ? SUB_B64 : SUB_COMPAT));

  p_legacy_sub_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && !lm_active |=>
      w.major == 1'b0 &&
      w.sub == (!$past(ctl_pe) ? SUB_REAL : ($past(fl_vm) ? SUB_V86 : SUB_PROT)));

  p_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> w.cpl == $past(cs_cpl) && w.paging == $past(ctl_pg) &&
               w.prot == $past(ctl_pe));

  p_op_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> w.op_def != w.op_alt && w.op_def != SZ64 && w.op_alt != SZ64);

  p_addr64_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && lm_active && cs_long |=> w.ad_def == SZ64 && w.ad_alt == SZ32);

  p_stack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && !(lm_active && cs_long) |=>
      w.stk == ($past(ss_big) ? SZ32 : SZ16));
endmodule

bind opmode_decoder opmode_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lm_active (lm_active),
  .ctl_pe    (ctl_pe),
  .ctl_pg    (ctl_pg),
  .fl_vm     (fl_vm),
  .cs_long   (cs_long),
  .cs_big    (cs_big),
  .cs_cpl    (cs_cpl),
  .ss_big    (ss_big),
  .ctl_wr    (ctl_wr),
  .mode_wr   (mode_wr),
  .mode_word (mode_word)
);

// File: tb/sim_opmode_decoder.sv
`timescale 1ns/1ps
module sim_opmode_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lm_active = 0, ctl_pe = 0, ctl_pg = 0, fl_vm = 0;
  logic        cs_long = 0, cs_big = 0, ss_big = 0;
  logic [1:0]  cs_cpl = 0;
  logic        ctl_wr = 0, mode_wr = 0;
  logic [17:0] mode_wr_data = 0;
  logic [17:0] mode_word;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct {
    logic [17:0] word;
    bit          whole;
    string       tag;
    logic        lma;
  } item_t;
  item_t q[$];
  logic [17:0] model;

  always #5 clk = ~clk;

  opmode_decoder u0 (
    .clk(clk), .rst_n(rst_n), .lm_active(lm_active), .ctl_pe(ctl_pe),
    .ctl_pg(ctl_pg), .fl_vm(fl_vm), .cs_long(cs_long), .cs_big(cs_big),
    .cs_cpl(cs_cpl), .ss_big(ss_big), .ctl_wr(ctl_wr), .mode_wr(mode_wr),
    .mode_wr_data(mode_wr_data), .mode_word(mode_word)
  );

  task automatic chk(string req, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // Expected word from pin vector v: [0]lma [1]pe [2]pg [3]vm [4]cs_long
  // [5]cs_big [6]ss_big [8:7]cpl
  function automatic logic [17:0] ref_word(logic [8:0] v);
    logic [2:0] s;
    logic [1:0] od, oa, ad, aa, st;
    logic b64;
    b64 = v[0] & v[4];
    case ({v[0], v[1], v[3]})
      3'b000, 3'b001: s = 3'd0;
      3'b010:         s = 3'd1;
      3'b011:         s = 3'd2;
      default:        s = v[4] ? 3'd4 : 3'd3;
    endcase
    {od, oa} = (b64 | v[5]) ? {2'd2, 2'd1} : {2'd1, 2'd2};
    if (b64)       {ad, aa} = {2'd3, 2'd2};
    else if (v[5]) {ad, aa} = {2'd2, 2'd1};
    else           {ad, aa} = {2'd1, 2'd2};
    st = b64 ? 2'd3 : (v[6] ? 2'd2 : 2'd1);
    return {st, aa, ad, oa, od, v[1], v[2], v[8:7], v[0], s};
  endfunction

  task automatic step(logic [8:0] v, bit cw, bit mw, logic [17:0] dat, string tag);
    item_t it;
    @(negedge clk);
    {cs_cpl, ss_big, cs_big, cs_long, fl_vm, ctl_pg, ctl_pe, lm_active} = v;
    ctl_wr = cw;
    mode_wr = mw;
    mode_wr_data = dat;
    if (cw || mw) model = ref_word(v);
    it.word  = model;
    it.whole = (tag != "");
    it.tag   = tag;
    it.lma   = v[0];
    q.push_back(it);
  endtask

  // Monitor: one expected item per cycle, compared after the edge settles.
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      if (it.whole) chk(it.tag, int'(mode_word), int'(it.word));
      else begin
        chk(it.lma ? "R4 submode" : "R5 submode", int'(mode_word[3:0]), int'(it.word[3:0]));
        chk("R6 cpl/pg/pe", int'(mode_word[7:4]), int'(it.word[7:4]));
        chk("R7 operand", int'(mode_word[11:8]), int'(it.word[11:8]));
        chk("R8 address", int'(mode_word[15:12]), int'(it.word[15:12]));
        chk("R9 stack", int'(mode_word[17:16]), int'(it.word[17:16]));
      end
    end
  end

  initial begin
    model = '0;
    // R1: reset wins over a strobe
    {lm_active, ctl_pe, ctl_pg, cs_long, cs_big, ss_big} = '1;
    cs_cpl = 2'd3;
    ctl_wr = 1;
    repeat (3) @(posedge clk);
    #2 chk("R1 reset", int'(mode_word), 0);
    @(negedge clk);
    ctl_wr = 0;
    rst_n = 1;
    step(9'h1FF, 0, 0, 18'h0, "R2 idle after reset");

    for (int i = 0; i < 512; i++)
      step(9'(i), (i % 2) == 0, (i % 2) == 1, 18'(i * 769), "");

    // R2: pins move without a strobe, word holds
    step(9'h017, 1, 0, 18'h0, "");
    step(9'h0E8, 0, 0, 18'h0, "R2 hold");
    step(9'h1A3, 0, 0, 18'h3FFFF, "R2 hold");
    step(9'h1A3, 1, 0, 18'h0, "R2 load");

    // R3: mode register writes with differing data give the same word
    step(9'h071, 0, 1, 18'h00000, "R3 data 0");
    step(9'h071, 0, 1, 18'h3FFFF, "R3 data ones");
    step(9'h071, 0, 1, 18'h2A5A5, "R3 data mix");
    step(9'h00A, 0, 1, 18'h3FFFF, "R3 recompute");
    step(9'h00A, 0, 0, 18'h0, "R2 final idle");

    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule